// File: doc/BRIEF.md
# SDRAM Command Decoder and Two-Bank Row Tracker

This block watches the command strobes, bank bit and address pins of a two-bank synchronous DRAM and keeps a cycle-accurate picture of what the memory is doing. On every rising clock edge where clock enable is high it samples the strobes. It names the command, updates which rows are open in each bank and follows the current burst. It also raises a one-cycle error flag when the command is not legal in the current bank state. A memory model, a protocol monitor or a controller self-check can use it to know which bank is open on which row without repeating the decoding itself.

Address bit 10 has two roles. On a precharge it chooses between closing both banks and closing only the named bank. On a read or write it asks for the bank to close by itself once the burst ends. The two banks keep separate state, so one can close while the other carries on with a burst. The burst length comes from the mode word written by LOAD MODE REGISTER. Timing parameters, the storage array and self refresh are not modelled.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: After reset both banks are idle, both row outputs and the mode word are zero, the command output reads NOP (0), the error flag is low and no burst is in progress.
- R2: Strobes {cs_n,ras_n,cas_n,we_n} decode as 0111 NOP, 0011 ACTIVE, 0101 READ, 0100 WRITE, 0010 PRECHARGE, 0110 BURST TERMINATE, 0001 AUTO REFRESH and 0000 LOAD MODE REGISTER. cmd_code reports these as 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 TERMINATE, 6 REFRESH, 7 LOAD MODE. With cs_n high the command reads as NOP and changes no state. Every output reflects the command sampled at the most recent enabled edge.
- R3: ACTIVE to an idle bank (selected by ba) marks it open and stores the 11 address bits as that bank's row.
- R4: ACTIVE to a bank that is already open sets err for that cycle and leaves both rows and the open flags unchanged.
- R5: READ or WRITE to an idle bank sets err and starts no burst.
- R6: PRECHARGE with addr[10] high closes both banks. With addr[10] low it closes only the bank named by ba. A burst in a bank being closed ends at once.
- R7: READ or WRITE to an open bank starts a burst in that bank. If addr[10] was high, the bank closes on the enabled edge that comes burst-length edges after the command edge. If addr[10] was low, the bank stays open.
- R8: LOAD MODE REGISTER stores {ba, addr} as a 12-bit mode word. Mode bits 2:0 set the burst length: 0, 1, 2 and 3 give 1, 2, 4 and 8 beats, and any other value gives a full page of 256 beats.
- R9: AUTO REFRESH while any bank is open sets err.
- R10: BURST TERMINATE ends the current burst. If that burst carried a pending auto precharge, its bank closes on the same edge.
- R11: READ or WRITE to the other bank during an auto-precharge burst closes the first bank on that edge and starts the new burst. READ or WRITE to the bank that has the pending auto precharge sets err, and the running burst continues.
- R12: While cke is low the block holds every state bit and output, including the burst count, so a burst resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes the block |
| cs_n | input | 1 | Chip select strobe, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 1 | Bank select |
| addr | input | 11 | Row, column, auto-precharge / all-bank bit, op-code |
| cmd_code | output | 3 | Last sampled command |
| err | output | 1 | Last sampled command was illegal |
| bank_open | output | 2 | Open flag per bank (bit n for bank n) |
| row_b0 | output | 11 | Open row of bank 0 |
| row_b1 | output | 11 | Open row of bank 1 |
| mode_word | output | 12 | Stored mode word |
| burst_on | output | 1 | A burst is in progress |
| ap_pending | output | 1 | The current burst ends with an auto precharge |

## Verification
Every result of a command shows on the outputs just after the same enabled rising edge that samples it. The bench drives each command on a falling edge and queues the expected output set. The monitor compares that set shortly after the next rising edge. An auto precharge closes its bank exactly burst-length edges after the READ or WRITE, so the bench sends one NOP per beat and expects the close on the last one. For the full page that means 256 NOP steps. Cycles with clock enable low also queue an expectation, and it equals the previous one. Counting those cycles shows that a frozen burst ends later by exactly the number of frozen cycles.

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker #(
  parameter int ROW_W = 11,
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             ba,
  input  logic [ROW_W-1:0] addr,
  output logic [2:0]       cmd_code,
  output logic             err,
  output logic [1:0]       bank_open,
  output logic [ROW_W-1:0] row_b0,
  output logic [ROW_W-1:0] row_b1,
  output logic [ROW_W:0]   mode_word,
  output logic             burst_on,
  output logic             ap_pending
);
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_BST = 3'd5, C_REF = 3'd6, C_LMR = 3'd7;
  localparam int APB = 10;
  localparam logic [COL_W-1:0] PAGE_M1 = {COL_W{1'b1}};

  logic [2:0]       dec;
  logic [COL_W-1:0] cnt, n_cnt, len_m1;
  logic             burst_bank, n_bb, n_burst, n_ap, n_err;
  logic [1:0]       n_open;
  logic [ROW_W-1:0] n_row0, n_row1;
  logic [ROW_W:0]   n_mode;

  always_comb begin
    if (cs_n) dec = C_NOP;
    else case ({ras_n, cas_n, we_n})
      3'b111: dec = C_NOP;
      3'b011: dec = C_ACT;
      3'b101: dec = C_RD;
      3'b100: dec = C_WR;
      3'b010: dec = C_PRE;
      3'b110: dec = C_BST;
      3'b001: dec = C_REF;
      default: dec = C_LMR;
    endcase
  end

  assign len_m1 = (mode_word[2:0] < 3'd4) ?
                  COL_W'((1 << mode_word[1:0]) - 1) : PAGE_M1;

  always_comb begin
    n_open  = bank_open;
    n_row0  = row_b0;
    n_row1  = row_b1;
    n_mode  = mode_word;
    n_burst = burst_on;
    n_bb    = burst_bank;
    n_ap    = ap_pending;
    n_cnt   = cnt;
    n_err   = 1'b0;
    if (burst_on) begin
      if (cnt == '0) begin
        n_burst = 1'b0;
        n_ap    = 1'b0;
        if (ap_pending) n_open[burst_bank] = 1'b0;
      end else begin
        n_cnt = cnt - 1'b1;
      end
    end
    case (dec)
      C_ACT: begin
        if (bank_open[ba]) n_err = 1'b1;
        else begin
          n_open[ba] = 1'b1;
          if (ba) n_row1 = addr;
          else    n_row0 = addr;
        end
      end
      C_RD, C_WR: begin
        if (!bank_open[ba] || (burst_on && ap_pending && burst_bank == ba))
          n_err = 1'b1;
        else begin
          if (burst_on && ap_pending) n_open[burst_bank] = 1'b0;
          n_burst = 1'b1;
          n_bb    = ba;
          n_ap    = addr[APB];
          n_cnt   = len_m1;
        end
      end
      C_PRE: begin
        if (addr[APB]) n_open = 2'b00;
        else           n_open[ba] = 1'b0;
        if (burst_on && (addr[APB] || burst_bank == ba)) begin
          n_burst = 1'b0;
          n_ap    = 1'b0;
        end
      end
      C_BST: begin
        if (burst_on) begin
          n_burst = 1'b0;
          n_ap    = 1'b0;
          if (ap_pending) n_open[burst_bank] = 1'b0;
        end
      end
      C_REF: if (|bank_open) n_err = 1'b1;
      C_LMR: n_mode = {ba, addr};
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_code   <= C_NOP;
      err        <= 1'b0;
      bank_open  <= 2'b00;
      row_b0     <= '0;
      row_b1     <= '0;
      mode_word  <= '0;
      burst_on   <= 1'b0;
      ap_pending <= 1'b0;
      burst_bank <= 1'b0;
      cnt        <= '0;
    end else if (cke) begin
      cmd_code   <= dec;
      err        <= n_err;
      bank_open  <= n_open;
      row_b0     <= n_row0;
      row_b1     <= n_row1;
      mode_word  <= n_mode;
      burst_on   <= n_burst;
      ap_pending <= n_ap;
      burst_bank <= n_bb;
      cnt        <= n_cnt;
    end
  end

  // R4
  act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke && dec == C_ACT && bank_open[ba] |=> err && $stable(row_b0) && $stable(row_b1));
  // R5
  rw_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke && (dec == C_RD || dec == C_WR) && !bank_open[ba] |=> err);
  // R6
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke && dec == C_PRE && addr[APB] |=> bank_open == 2'b00);
  // R9
  ref_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke && dec == C_REF && (|bank_open) |=> err);
  // R12
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> $stable(bank_open) && $stable(cmd_code) && $stable(burst_on) && $stable(err));
  // R3
  act_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke && dec == C_ACT && !bank_open[ba] |=> bank_open[$past(ba)] && !err);
endmodule

// File: tb/test_sdram_cmd_tracker.sv
module test_sdram_cmd_tracker;
  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, ba = 1'b0;
  logic [10:0] addr = '0;
  logic [2:0]  cmd_code;
  logic        err, burst_on, ap_pending;
  logic [1:0]  bank_open;
  logic [10:0] row_b0, row_b1;
  logic [11:0] mode_word;

  sdram_cmd_tracker i_sdram_cmd_tracker (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd_code(cmd_code),
    .err(err), .bank_open(bank_open), .row_b0(row_b0), .row_b1(row_b1),
    .mode_word(mode_word), .burst_on(burst_on), .ap_pending(ap_pending));

  always #2 clk = ~clk;

  typedef struct {
    string       tag;
    logic [2:0]  c;
    logic        e;
    logic [1:0]  o;
    logic [10:0] r0;
    logic [10:0] r1;
    logic [11:0] m;
    logic        b;
    logic        a;
  } exp_t;

  exp_t q[$];
  exp_t ex;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [1:0]  eo = 0;
  logic [10:0] er0 = 0, er1 = 0;
  logic [11:0] em = 0;
  logic        eb = 0, ea = 0;

  localparam logic [3:0] S_NOP = 4'b0111, S_ACT = 4'b0011, S_RD = 4'b0101,
    S_WR = 4'b0100, S_PRE = 4'b0010, S_BST = 4'b0110, S_REF = 4'b0001, S_LMR = 4'b0000;

  task automatic st(logic [1:0] o, logic b, logic a);
    eo = o; eb = b; ea = a;
  endtask

  task automatic step(string tag, logic ck, logic [3:0] s, logic b, logic [10:0] a,
                      logic [2:0] ec, logic ee);
    exp_t x;
    @(negedge clk);
    cke = ck; {cs_n, ras_n, cas_n, we_n} = s; ba = b; addr = a;
    x = '{tag, ec, ee, eo, er0, er1, em, eb, ea};
    q.push_back(x);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      ex = q.pop_front();
      checks++;
      if ({cmd_code, err, bank_open, row_b0, row_b1, mode_word, burst_on, ap_pending} !==
          {ex.c, ex.e, ex.o, ex.r0, ex.r1, ex.m, ex.b, ex.a}) begin
        fails++;
        $display("FAIL %s: got cmd=%0d err=%0b open=%b r0=%h r1=%h mode=%h burst=%0b ap=%0b exp cmd=%0d err=%0b open=%b r0=%h r1=%h mode=%h burst=%0b ap=%0b",
          ex.tag, cmd_code, err, bank_open, row_b0, row_b1, mode_word, burst_on, ap_pending,
          ex.c, ex.e, ex.o, ex.r0, ex.r1, ex.m, ex.b, ex.a);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({cmd_code, err, bank_open, row_b0, row_b1, mode_word, burst_on, ap_pending} !== '0) begin
      fails++;
      $display("FAIL R1 reset: got %h exp 0",
        {cmd_code, err, bank_open, row_b0, row_b1, mode_word, burst_on, ap_pending});
    end
    @(negedge clk); rst_n = 1'b1;

    step("R2 inhibit", 1, 4'b1011, 0, 11'h005, 0, 0);
    er0 = 11'h123; st(2'b01, 0, 0);
    step("R3 act b0", 1, S_ACT, 0, 11'h123, 1, 0);
    er1 = 11'h7FF; st(2'b11, 0, 0);
    step("R3 act b1", 1, S_ACT, 1, 11'h7FF, 1, 0);
    step("R4 act open", 1, S_ACT, 0, 11'h055, 1, 1);
    st(2'b01, 0, 0);
    step("R6 pre one", 1, S_PRE, 1, 11'h000, 4, 0);
    step("R5 wr idle", 1, S_WR, 1, 11'h003, 3, 1);
    step("R9 ref open", 1, S_REF, 0, 11'h000, 6, 1);
    st(2'b00, 0, 0);
    step("R6 pre all", 1, S_PRE, 0, 11'h400, 4, 0);
    step("R2 ref idle", 1, S_REF, 0, 11'h000, 6, 0);
    em = 12'h002;
    step("R8 lmr len4", 1, S_LMR, 0, 11'h002, 7, 0);
    er0 = 11'h0AA; st(2'b01, 0, 0);
    step("R3 act", 1, S_ACT, 0, 11'h0AA, 1, 0);
    st(2'b01, 1, 1);
    step("R7 rd ap", 1, S_RD, 0, 11'h410, 2, 0);
    for (int i = 0; i < 3; i++) step("R7 beat", 1, S_NOP, 0, 0, 0, 0);
    st(2'b00, 0, 0);
    step("R7 ap close", 1, S_NOP, 0, 0, 0, 0);

    er1 = 11'h001; st(2'b10, 0, 0);
    step("R3 act b1", 1, S_ACT, 1, 11'h001, 1, 0);
    st(2'b10, 1, 0);
    step("R7 rd noap", 1, S_RD, 1, 11'h003, 2, 0);
    for (int i = 0; i < 3; i++) step("R7 beat", 1, S_NOP, 0, 0, 0, 0);
    st(2'b10, 0, 0);
    step("R7 stays open", 1, S_NOP, 0, 0, 0, 0);
    st(2'b10, 1, 1);
    step("R7 wr ap", 1, S_WR, 1, 11'h400, 3, 0);
    st(2'b00, 0, 0);
    step("R10 bst", 1, S_BST, 0, 0, 5, 0);

    er0 = 11'h200; st(2'b01, 0, 0);
    step("R3 act", 1, S_ACT, 0, 11'h200, 1, 0);
    er1 = 11'h300; st(2'b11, 0, 0);
    step("R3 act", 1, S_ACT, 1, 11'h300, 1, 0);
    st(2'b11, 1, 1);
    step("R11 rd ap", 1, S_RD, 0, 11'h400, 2, 0);
    step("R11 same bank", 1, S_RD, 0, 11'h001, 2, 1);
    st(2'b10, 1, 0);
    step("R11 concurrent", 1, S_WR, 1, 11'h005, 3, 0);
    step("R12 frozen", 0, S_ACT, 0, 11'h011, 3, 0);
    step("R12 frozen", 0, S_PRE, 0, 11'h400, 3, 0);
    for (int i = 0; i < 3; i++) step("R12 beat", 1, S_NOP, 0, 0, 0, 0);
    st(2'b10, 0, 0);
    step("R12 late end", 1, S_NOP, 0, 0, 0, 0);

    em = 12'h807;
    step("R8 lmr page", 1, S_LMR, 1, 11'h007, 7, 0);
    st(2'b10, 1, 1);
    step("R8 rd page", 1, S_RD, 1, 11'h400, 2, 0);
    for (int i = 0; i < 255; i++) step("R8 page beat", 1, S_NOP, 0, 0, 0, 0);
    st(2'b00, 0, 0);
    step("R8 page close", 1, S_NOP, 0, 0, 0, 0);

    em = 12'h000;
    step("R8 lmr len1", 1, S_LMR, 0, 11'h000, 7, 0);
    step("R5 rd idle", 1, S_RD, 0, 11'h400, 2, 1);
    er0 = 11'h0F0; st(2'b01, 0, 0);
    step("R3 act", 1, S_ACT, 0, 11'h0F0, 1, 0);
    st(2'b01, 1, 1);
    step("R8 rd len1", 1, S_RD, 0, 11'h400, 2, 0);
    st(2'b00, 0, 0);
    step("R8 len1 close", 1, S_NOP, 0, 0, 0, 0);

    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule